// File: doc/BRIEF.md
# Descriptor Read Skip Controller

This block sits in front of a descriptor-driven transfer engine. It decides, for every transfer request it accepts, whether the engine must fetch the vector entry and descriptor from memory again, or can run on the descriptor it already holds. To make that choice it keeps three things from earlier requests:

- the vector number of the last descriptor fetched, with a flag that says whether that number is still valid;
- a force flag, set by the status of the last finished transfer;
- the skip-enable control level, which it watches every cycle.

Requests arrive on a valid/ready stream. `req_ready` is high only while the block is idle. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both high, and the source must hold `req_vec` steady until then. After a request is taken, `req_ready` stays low until the engine reports the end of the transfer, so the source is held back for the whole fetch and transfer.

The decision comes out one cycle after acceptance as a one-cycle strobe. When the decision is to fetch, the block waits for the memory side to report `fetch_done`. It then moves on to the transfer phase and waits for `xfer_done`, which carries the status of the finished transfer. The fetch itself and the data movement are outside this block.

Top module: `desc_skip_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `dec_valid` is 0 and no vector is retained, so the first request after reset always decides to fetch (`dec_fetch`=1).
- R2: `dec_valid` is high for exactly the one cycle after a request is accepted, and `dec_vec` then equals the vector number that was accepted.
- R3: The decision is to skip (`dec_fetch`=0) only when all of these hold: skip-enable is 1 at acceptance, a retained vector is valid, it equals the request vector, and no force condition is pending.
- R4: A request whose vector differs from the retained vector decides to fetch.
- R5: A request accepted while skip-enable is 0 decides to fetch, even when its vector matches the retained one.
- R6: If the previous transfer ended with `xfer_chain`=1, the next request decides to fetch.
- R7: If the previous transfer was in normal mode (`xfer_mode`=2'b00, and 2'b11 is handled the same way) and ended with `xfer_cnt_zero`=1, the next request decides to fetch.
- R8: If the previous transfer was in block mode (`xfer_mode`=2'b10) and ended with `xfer_cnt_zero`=1, the next request decides to fetch.
- R9: If the previous transfer was in repeat mode (`xfer_mode`=2'b01), `xfer_cnt_zero`=1 does not force a fetch.
- R10: Any cycle with skip-enable at 0 discards the retained vector, so the next request fetches.
- R11: Sequencing and retention:
  - `req_ready` stays 0 from acceptance until the cycle after `xfer_done`;
  - after a fetch decision, `xfer_done` is ignored until `fetch_done` has been seen;
  - the retained vector is updated only when a fetch completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| skip_en | input | 1 | Skip-enable control level; 0 discards the retained vector |
| req_valid | input | 1 | Transfer request is present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_vec | input | VEC_W | Vector number of the request |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_fetch | output | 1 | 1 = fetch the descriptor, 0 = reuse the held one |
| dec_vec | output | VEC_W | Vector number the decision applies to |
| fetch_done | input | 1 | Memory fetch of the descriptor has completed |
| xfer_done | input | 1 | Transfer has finished; its status is valid this cycle |
| xfer_chain | input | 1 | The finished transfer was chained |
| xfer_mode | input | 2 | Mode of the finished transfer: 00 normal, 01 repeat, 10 block |
| xfer_cnt_zero | input | 1 | The finished transfer's counter reached zero |

## Verification
The decision strobe and vector are due in the first cycle after the accepting edge, so the bench raises `req_valid` at a falling edge and reads `dec_valid`, `dec_fetch` and `dec_vec` at the next falling edge. The bench then checks that `dec_valid` has dropped one cycle later. A `fetch_done` or `xfer_done` pulse takes effect on the edge that samples it: the bench checks `req_ready` one falling edge after `xfer_done`. It also checks that `req_ready` is still low during the phases before that pulse. Changes to skip-enable and to history are always applied whole cycles before the request they should affect.

// File: rtl/desc_skip_pkg.sv
package desc_skip_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_REPEAT = 2'b01,
    MODE_BLOCK  = 2'b10,
    MODE_RSVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FETCH = 2'b01,
    ST_XFER  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/desc_skip_hist.sv
module desc_skip_hist
  import desc_skip_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             skip_en,
  input  logic             fetch_fire,
  input  logic [VEC_W-1:0] fetch_vec,
  input  logic             xfer_fire,
  input  logic             xfer_chain,
  input  logic [1:0]       xfer_mode,
  input  logic             xfer_cnt_zero,
  output logic             ret_valid,
  output logic [VEC_W-1:0] ret_vec,
  output logic             force_fetch
);
  // Counter exhaustion forces a reload in every mode except repeat,
  // where the counter reloads itself and the descriptor stays usable.
  logic exhausted;
  assign exhausted = xfer_cnt_zero && (xfer_mode != MODE_REPEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
    end else if (!skip_en) begin
      ret_valid <= 1'b0;
    end else if (fetch_fire) begin
      ret_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_vec <= '0;
    end else if (fetch_fire) begin
      ret_vec <= fetch_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_fetch <= 1'b0;
    end else if (xfer_fire) begin
      force_fetch <= xfer_chain || exhausted;
    end
  end
endmodule

// File: rtl/desc_skip_cmp.sv
module desc_skip_cmp #(
  parameter int VEC_W = 8
) (
  input  logic             skip_en,
  input  logic             ret_valid,
  input  logic [VEC_W-1:0] ret_vec,
  input  logic             force_fetch,
  input  logic [VEC_W-1:0] req_vec,
  output logic             need_fetch
);
  logic vec_hit;

  always_comb begin
    vec_hit    = ret_valid && (ret_vec == req_vec);
    need_fetch = !(skip_en && vec_hit && !force_fetch);
  end
endmodule

// File: rtl/desc_skip_seq.sv
module desc_skip_seq
  import desc_skip_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             need_fetch,
  input  logic             fetch_done,
  input  logic             xfer_done,
  output logic             req_ready,
  output logic             accept,
  output logic             dec_valid,
  output logic             dec_fetch,
  output logic [VEC_W-1:0] dec_vec,
  output logic             fetch_fire,
  output logic             xfer_fire
);
  seq_state_e state_q, state_d;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign fetch_fire = (state_q == ST_FETCH) && fetch_done;
  assign xfer_fire  = (state_q == ST_XFER) && xfer_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = need_fetch ? ST_FETCH : ST_XFER;
      ST_FETCH: if (fetch_done) state_d = ST_XFER;
      ST_XFER:  if (xfer_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dec_valid <= 1'b0;
      dec_fetch <= 1'b0;
      dec_vec   <= '0;
    end else begin
      state_q   <= state_d;
      dec_valid <= accept;
      if (accept) begin
        dec_fetch <= need_fetch;
        dec_vec   <= req_vec;
      end
    end
  end
endmodule

// File: rtl/desc_skip_ctrl.sv
module desc_skip_ctrl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             skip_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vec,
  output logic             dec_valid,
  output logic             dec_fetch,
  output logic [VEC_W-1:0] dec_vec,
  input  logic             fetch_done,
  input  logic             xfer_done,
  input  logic             xfer_chain,
  input  logic [1:0]       xfer_mode,
  input  logic             xfer_cnt_zero
);
  logic             ret_valid;
  logic [VEC_W-1:0] ret_vec;
  logic             force_fetch;
  logic             need_fetch;
  logic             accept;
  logic             fetch_fire;
  logic             xfer_fire;

  desc_skip_seq #(.VEC_W(VEC_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vec(req_vec),
    .need_fetch(need_fetch),
    .fetch_done(fetch_done), .xfer_done(xfer_done),
    .req_ready(req_ready), .accept(accept),
    .dec_valid(dec_valid), .dec_fetch(dec_fetch), .dec_vec(dec_vec),
    .fetch_fire(fetch_fire), .xfer_fire(xfer_fire)
  );

  desc_skip_cmp #(.VEC_W(VEC_W)) u_cmp (
    .skip_en(skip_en), .ret_valid(ret_valid), .ret_vec(ret_vec),
    .force_fetch(force_fetch), .req_vec(req_vec),
    .need_fetch(need_fetch)
  );

  // The fetched vector is the one latched into dec_vec at acceptance.
  desc_skip_hist #(.VEC_W(VEC_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .skip_en(skip_en),
    .fetch_fire(fetch_fire), .fetch_vec(dec_vec),
    .xfer_fire(xfer_fire), .xfer_chain(xfer_chain),
    .xfer_mode(xfer_mode), .xfer_cnt_zero(xfer_cnt_zero),
    .ret_valid(ret_valid), .ret_vec(ret_vec), .force_fetch(force_fetch)
  );
endmodule

// File: rtl/desc_skip_ctrl_chk.sv
module desc_skip_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             skip_en,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VEC_W-1:0] req_vec,
  input logic             dec_valid,
  input logic             dec_fetch,
  input logic [VEC_W-1:0] dec_vec,
  input logic             fetch_done,
  input logic             xfer_done,
  input logic             ret_valid,
  input logic [VEC_W-1:0] ret_vec
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_strobe_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (dec_valid && dec_vec == $past(req_vec)));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  assert_skip_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !skip_en |=> dec_fetch);

  assert_cold_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ret_valid |=> dec_fetch);

  assert_mismatch_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_vec != ret_vec) |=> dec_fetch);

  assert_disable_discards_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_en |=> !ret_valid);
endmodule

bind desc_skip_ctrl desc_skip_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .skip_en(skip_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_vec(req_vec),
  .dec_valid(dec_valid), .dec_fetch(dec_fetch), .dec_vec(dec_vec),
  .fetch_done(fetch_done), .xfer_done(xfer_done),
  .ret_valid(ret_valid), .ret_vec(ret_vec)
);

// File: tb/desc_skip_ctrl_bench.sv
module desc_skip_ctrl_bench;
  localparam int VW = 8;
  localparam int NV = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          skip_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [VW-1:0] req_vec = '0;
  logic          dec_valid;
  logic          dec_fetch;
  logic [VW-1:0] dec_vec;
  logic          fetch_done = 1'b0;
  logic          xfer_done = 1'b0;
  logic          xfer_chain = 1'b0;
  logic [1:0]    xfer_mode = 2'b00;
  logic          xfer_cnt_zero = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  desc_skip_ctrl #(.VEC_W(VW)) u_desc_skip_ctrl (
    .clk(clk), .rst_n(rst_n), .skip_en(skip_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_vec(req_vec),
    .dec_valid(dec_valid), .dec_fetch(dec_fetch), .dec_vec(dec_vec),
    .fetch_done(fetch_done), .xfer_done(xfer_done),
    .xfer_chain(xfer_chain), .xfer_mode(xfer_mode),
    .xfer_cnt_zero(xfer_cnt_zero)
  );

  // Entry fields: [15:8] vector, [7] skip_en, [6] chain status,
  // [5:4] mode status, [3] counter-zero status, [2] expected fetch.
  // The status fields describe the transfer that this entry completes.
  localparam logic [15:0] TBL [NV] = '{
    {8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R1 cold fetch
    {8'd5, 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 2'b00}, // R3 skip
    {8'd5, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00}, // R9 repeat zero, still skip
    {8'd5, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 2'b00}, // R6 after chain
    {8'd5, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 2'b00}, // R7 after normal zero
    {8'd5, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 2'b00}, // R3 block nonzero skip
    {8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R8 after block zero
    {8'd9, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R4 mismatch
    {8'd9, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00}, // R3 retained 9
    {8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R4 mismatch
    {8'd5, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R5 match, enable 0
    {8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 2'b00}, // R10 discarded
    {8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00}  // R3 skip again
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [VW-1:0] vec, input logic sk, input logic ch,
                         input logic [1:0] md, input logic cz, input logic exp,
                         input string tag);
    @(negedge clk);
    skip_en = sk;
    req_vec = vec;
    check(req_ready == 1'b1, "R11 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(dec_valid == 1'b1, "R2 strobe", int'(dec_valid), 1);
    check(dec_vec == vec, "R2 vector", int'(dec_vec), int'(vec));
    check(dec_fetch == exp, tag, int'(dec_fetch), int'(exp));
    @(negedge clk);
    check(dec_valid == 1'b0, "R2 single strobe", int'(dec_valid), 0);
    check(req_ready == 1'b0, "R11 busy", int'(req_ready), 0);
    if (exp) begin
      // xfer_done before the fetch completes must be ignored (R11)
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      check(req_ready == 1'b0, "R11 xfer_done ignored in fetch", int'(req_ready), 0);
      fetch_done = 1'b1;
      @(negedge clk);
      fetch_done = 1'b0;
      check(req_ready == 1'b0, "R11 busy after fetch", int'(req_ready), 0);
    end
    xfer_chain = ch;
    xfer_mode = md;
    xfer_cnt_zero = cz;
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    xfer_chain = 1'b0;
    xfer_cnt_zero = 1'b0;
    xfer_mode = 2'b00;
    check(req_ready == 1'b1, "R11 ready after xfer_done", int'(req_ready), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    check(dec_valid == 1'b0, "R1 no strobe in reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(dec_valid == 1'b0, "R1 no strobe after reset", int'(dec_valid), 0);

    for (int i = 0; i < NV; i++) begin
      run_req(TBL[i][15:8], TBL[i][7], TBL[i][6], TBL[i][5:4], TBL[i][3],
              TBL[i][2], $sformatf("R3/R9 table entry %0d decision", i));
    end

    // R10: one idle cycle with skip_en low discards the retained vector 5
    @(negedge clk);
    skip_en = 1'b0;
    @(negedge clk);
    skip_en = 1'b1;
    run_req(8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R10 fetch after enable drop");
    run_req(8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R3 skip after refetch");

    // R7: reserved mode 2'b11 with counter zero behaves like normal mode
    run_req(8'd5, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, "R3 skip before reserved zero");
    run_req(8'd5, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, "R7 fetch after mode 11 zero");

    // R11: a request held while busy is not taken
    @(negedge clk);
    req_vec = 8'd7;
    req_valid = 1'b1;
    @(negedge clk);
    check(dec_valid == 1'b1 && dec_fetch == 1'b1, "R4 vector 7 fetches", int'(dec_fetch), 1);
    @(negedge clk);
    check(dec_valid == 1'b0, "R11 held request not retaken", int'(dec_valid), 0);
    req_valid = 1'b0;
    fetch_done = 1'b1;
    @(negedge clk);
    fetch_done = 1'b0;
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(req_ready == 1'b1, "R11 idle after vector 7", int'(req_ready), 1);
    run_req(8'd7, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R11 retained vector 7 skip");

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule